// File: doc/BRIEF.md
# Transmit frame byte serializer

This block turns one transmit frame into a tagged serial stream for a downstream modulator. A frame is a run of data bytes, each optionally followed by a parity bit, and then an optional stop symbol. A start pulse latches the frame settings: the byte count, data enable, parity enable, parity type, last-parity invert and the stop-symbol select. Bytes then arrive one at a time through a valid/ready handshake. Each bit leaves on its own output together with a tag that says whether it is a data bit, a parity bit or a symbol. The consumer advances the stream with a bit-time enable. While that enable is low, the presented item stays on the outputs.

The block can also run a frame with data transmission switched off. In that case it sends only the stop symbol and consumes no bytes. If data transmission is requested with a byte count of zero, the frame is refused and a sticky error flag rises. A frame that finishes normally ends with a single-cycle done pulse.

Top module: `txser_top`

## Requirements
- R1: Data bits of each byte leave one per cycle in which `out_valid` and `bit_en` are both high, least significant bit first, tagged data (tag encoding: none=0, data=1, parity=2, symbol=3). While `bit_en` is low the presented bit and tag hold.
- R2: With parity enabled, exactly one parity-tagged bit follows bit 7 of every byte. With parity disabled, no parity-tagged bit appears.
- R3: Parity type 0 gives even parity, where the parity bit equals the XOR of the eight data bits. Parity type 1 gives odd parity, which is the complement of that XOR.
- R4: With last-parity invert set, only the parity bit of the frame's final byte is complemented. The parity of every other byte is unchanged.
- R5: A start with data enabled and byte count 0 sets `err` from the cycle after start. No byte is accepted, no item is presented and no done pulse occurs. `err` stays high until the next start, which clears it.
- R6: With data disabled, `in_ready` never rises during the frame, no byte is consumed and only the stop symbol (if any) is presented.
- R7: Stop select 0 sends no symbol. Selects 1, 2 and 3 present `SYM_LEN` symbol-tagged items carrying `out_sym` equal to the select value. These come after the last data or parity bit.
- R8: A successful frame ends with `done` high for exactly one cycle, after the last item is consumed. If the frame has no items, `done` follows the start directly. Afterwards `in_ready` and `out_valid` are low.
- R9: When data is enabled, exactly the requested number of bytes is accepted, each on a cycle with `in_valid` and `in_ready` both high. The bytes are transmitted in arrival order.
- R10: After reset, `out_valid`, `in_ready`, `done` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a frame when the block is idle; latches the settings below |
| cfg_byte_cnt | input | CNT_W | Number of data bytes in the frame |
| cfg_data_en | input | 1 | 1 = send data bytes, 0 = symbols only |
| cfg_par_en | input | 1 | Append a parity bit after each byte |
| cfg_par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| cfg_par_last_inv | input | 1 | Complement the parity of the final byte |
| cfg_stop_sel | input | 2 | Stop symbol: 0 none, 1..3 symbol code |
| in_data | input | DATA_W | Byte to transmit |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| bit_en | input | 1 | Bit-time enable; consumes the presented item |
| out_valid | output | 1 | An item is presented |
| out_bit | output | 1 | Data or parity bit value (0 for symbols) |
| out_tag | output | 2 | Item kind: 0 none, 1 data, 2 parity, 3 symbol |
| out_sym | output | 2 | Stop symbol code while tag is symbol, else 0 |
| done | output | 1 | One-cycle pulse at frame end |
| err | output | 1 | Sticky no-data error |

## Verification
The bench builds the block with 8-bit bytes, a 3-bit byte count and a stop symbol two bit-times long. At that size it can sweep every combination of byte count 0 to 3, data enable, parity enable, parity type, last invert and all four stop selects. The sweep covers the zero-count error, symbols-only frames, frames with no items at all, and the single-byte case where the first byte is also the last. The bit-time enable and the byte valid are stalled in patterns offset per frame. This exercises holds and handshake gaps at different points in the stream.

// File: rtl/txser_pkg.sv
package txser_pkg;

   typedef enum logic [1:0] {
      TAG_NONE = 2'd0,
      TAG_DATA = 2'd1,
      TAG_PAR  = 2'd2,
      TAG_SYM  = 2'd3
   } tag_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_BITS,
      ST_PAR,
      ST_SYM
   } state_e;

endpackage

// File: rtl/txser_parity.sv
module txser_parity #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] data,
   input  logic              odd,
   input  logic              flip,
   output logic              par
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("txser_parity: DATA_W must be at least 1");
      end
   endgenerate

   // even parity is the XOR of the byte; odd and final-byte invert each complement it
   assign par = (^data) ^ odd ^ flip;

endmodule

// File: rtl/txser_shift.sv
module txser_shift #(
   parameter int DATA_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              step,
   output logic              bit_o,
   output logic              last_o
);

   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("txser_shift: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] sh_q;
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (load) begin
         idx_q <= '0;
      end else if (step) begin
         idx_q <= idx_q + IDX_W'(1);
      end
   end

   assign last_o = (idx_q == IDX_W'(DATA_W - 1));

   generate
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sh_q <= '0;
            else if (load)  sh_q <= din;
            else if (step)  sh_q <= {1'b0, sh_q[DATA_W-1:1]};
         end
         assign bit_o = sh_q[0];
      end else begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sh_q <= '0;
            else if (load)  sh_q <= din;
            else if (step)  sh_q <= {sh_q[DATA_W-2:0], 1'b0};
         end
         assign bit_o = sh_q[DATA_W-1];
      end
   endgenerate

endmodule

// File: rtl/txser_symcnt.sv
module txser_symcnt #(
   parameter int SYM_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic last_o
);

   localparam int CW = (SYM_LEN > 1) ? $clog2(SYM_LEN) : 1;

   generate
      if (SYM_LEN < 1) begin : g_bad_len
         $error("txser_symcnt: SYM_LEN must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign last_o = (cnt_q == CW'(SYM_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (clear)                cnt_q <= '0;
      else if (step && last_o)       cnt_q <= '0;
      else if (step)                 cnt_q <= cnt_q + CW'(1);
   end

endmodule

// File: rtl/txser_top.sv
module txser_top
   import txser_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int CNT_W     = 8,
   parameter int SYM_LEN   = 4,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  cfg_byte_cnt,
   input  logic              cfg_data_en,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_par_last_inv,
   input  logic [1:0]        cfg_stop_sel,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              bit_en,
   output logic              out_valid,
   output logic              out_bit,
   output logic [1:0]        out_tag,
   output logic [1:0]        out_sym,
   output logic              done,
   output logic              err
);

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("txser_top: CNT_W must be at least 1");
      end
   endgenerate

   state_e            st_q, st_d;
   logic [CNT_W-1:0]  rem_q, rem_d;
   logic              den_q, pen_q, podd_q, pinv_q;
   logic [1:0]        stop_q;
   logic              par_q, done_q, err_q;
   logic              accept, fire, fin, err_set, take_start;
   logic              sh_bit, sh_last, sym_last, par_calc;
   state_e            after_byte;
   tag_e              tag;

   assign take_start = (st_q == ST_IDLE) && start;
   assign in_ready   = (st_q == ST_LOAD);
   assign accept     = in_ready && in_valid;
   assign out_valid  = (st_q == ST_BITS) || (st_q == ST_PAR) || (st_q == ST_SYM);
   assign fire       = out_valid && bit_en;

   txser_parity #(.DATA_W(DATA_W)) u_par (
      .data (in_data),
      .odd  (podd_q),
      .flip (pinv_q && (rem_q == CNT_W'(1))),
      .par  (par_calc)
   );

   txser_shift #(.DATA_W(DATA_W), .LSB_FIRST(LSB_FIRST)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .din    (in_data),
      .step   (fire && (st_q == ST_BITS)),
      .bit_o  (sh_bit),
      .last_o (sh_last)
   );

   txser_symcnt #(.SYM_LEN(SYM_LEN)) u_symcnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (st_q != ST_SYM),
      .step   (fire),
      .last_o (sym_last)
   );

   // where to go once a byte (and its parity) has been sent
   always_comb begin
      if (rem_q != '0)          after_byte = ST_LOAD;
      else if (stop_q != 2'd0)  after_byte = ST_SYM;
      else                      after_byte = ST_IDLE;
   end

   always_comb begin
      st_d    = st_q;
      rem_d   = rem_q;
      fin     = 1'b0;
      err_set = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) begin
               if (cfg_data_en && (cfg_byte_cnt == '0)) begin
                  err_set = 1'b1;
               end else if (cfg_data_en) begin
                  st_d  = ST_LOAD;
                  rem_d = cfg_byte_cnt;
               end else if (cfg_stop_sel != 2'd0) begin
                  st_d = ST_SYM;
               end else begin
                  fin = 1'b1;
               end
            end
         end
         ST_LOAD: begin
            if (accept) begin
               st_d  = ST_BITS;
               rem_d = rem_q - CNT_W'(1);
            end
         end
         ST_BITS: begin
            if (fire && sh_last) begin
               if (pen_q) begin
                  st_d = ST_PAR;
               end else begin
                  st_d = after_byte;
                  fin  = (after_byte == ST_IDLE);
               end
            end
         end
         ST_PAR: begin
            if (fire) begin
               st_d = after_byte;
               fin  = (after_byte == ST_IDLE);
            end
         end
         ST_SYM: begin
            if (fire && sym_last) begin
               st_d = ST_IDLE;
               fin  = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         rem_q  <= '0;
         den_q  <= 1'b0;
         pen_q  <= 1'b0;
         podd_q <= 1'b0;
         pinv_q <= 1'b0;
         stop_q <= 2'd0;
         par_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         rem_q  <= rem_d;
         done_q <= fin;
         if (take_start) begin
            den_q  <= cfg_data_en;
            pen_q  <= cfg_par_en;
            podd_q <= cfg_par_odd;
            pinv_q <= cfg_par_last_inv;
            stop_q <= cfg_stop_sel;
            err_q  <= err_set;
         end
         if (accept) begin
            par_q <= par_calc;
         end
      end
   end

   always_comb begin
      unique case (st_q)
         ST_BITS: tag = TAG_DATA;
         ST_PAR:  tag = TAG_PAR;
         ST_SYM:  tag = TAG_SYM;
         default: tag = TAG_NONE;
      endcase
   end

   assign out_tag = tag;
   assign out_bit = (st_q == ST_BITS) ? sh_bit : ((st_q == ST_PAR) ? par_q : 1'b0);
   assign out_sym = (st_q == ST_SYM) ? stop_q : 2'd0;
   assign done    = done_q;
   assign err     = err_q;

   AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !bit_en) |=> ($stable(out_bit) && $stable(out_tag))); // R1
   AST_PARITY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_tag == 2'd2)) |-> pen_q); // R2
   AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!out_valid && !in_ready && !done)); // R5
   AST_READY_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> den_q); // R6
   AST_SYM_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_tag == 2'd3) |-> ((out_sym != 2'd0) && (out_sym == stop_q))); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!out_valid && !in_ready)); // R8

endmodule

// File: tb/test_txser_top.sv
module test_txser_top;

   localparam int DW = 8;
   localparam int CW = 3;
   localparam int SL = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] cfg_byte_cnt = '0;
   logic          cfg_data_en = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_par_last_inv = 1'b0;
   logic [1:0]    cfg_stop_sel = 2'd0;
   logic [DW-1:0] in_data = '0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic          bit_en = 1'b0;
   logic          out_valid, out_bit;
   logic [1:0]    out_tag, out_sym;
   logic          done, err;

   int n_chk = 0;
   int n_err = 0;

   logic [4:0] exp_q[$];
   string      req_q[$];

   always #2 clk = ~clk;

   txser_top #(.DATA_W(DW), .CNT_W(CW), .SYM_LEN(SL), .LSB_FIRST(1'b1)) i_txser_top (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_byte_cnt(cfg_byte_cnt),
      .cfg_data_en(cfg_data_en), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_par_last_inv(cfg_par_last_inv), .cfg_stop_sel(cfg_stop_sel),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready), .bit_en(bit_en),
      .out_valid(out_valid), .out_bit(out_bit), .out_tag(out_tag), .out_sym(out_sym),
      .done(done), .err(err)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] gen_byte(input int f, input int k);
      return 8'((f * 37 + k * 101 + 5) & 255);
   endfunction

   // expected item packed as {tag[1:0], sym[1:0], bit}
   task automatic run_frame(input int cnt, input bit den, input bit pen, input bit podd,
                            input bit pinv, input int sel, input int f);
      bit   is_err;
      int   obs, acc, ndone, cyc;
      logic [7:0] b;
      logic p;
      exp_q.delete();
      req_q.delete();
      is_err = den && (cnt == 0);
      if (den) begin
         for (int k = 0; k < cnt; k++) begin
            b = gen_byte(f, k);
            for (int i = 0; i < 8; i++) begin
               exp_q.push_back({2'd1, 2'd0, b[i]});
               req_q.push_back("R1");
            end
            if (pen) begin
               p = 1'(($countones(b) % 2)) ^ podd ^ (pinv && (k == cnt - 1));
               exp_q.push_back({2'd2, 2'd0, p});
               req_q.push_back((pinv && (k == cnt - 1)) ? "R4" : "R3");
            end
         end
      end
      if (!is_err && sel != 0) begin
         for (int s = 0; s < SL; s++) begin
            exp_q.push_back({2'd3, 2'(sel), 1'b0});
            req_q.push_back("R7");
         end
      end

      @(negedge clk);
      cfg_byte_cnt     = CW'(cnt);
      cfg_data_en      = den;
      cfg_par_en       = pen;
      cfg_par_odd      = podd;
      cfg_par_last_inv = pinv;
      cfg_stop_sel     = 2'(sel);
      start            = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(err == is_err, "R5", "err after start", int'(err), int'(is_err));

      obs = 0; acc = 0; ndone = 0;
      for (cyc = 0; cyc < 300; cyc++) begin
         if (done) ndone++;
         if (is_err) begin
            chk(err && !out_valid && !in_ready && !done, "R5", "sticky silent error",
                {out_valid, in_ready, done, err}, 1);
            if (cyc >= 3) break;
         end
         if (ndone > 0) break;
         if (!den) chk(!in_ready, "R6", "ready while data disabled", int'(in_ready), 0);
         bit_en   = ((cyc + f) % 3) != 0;
         in_valid = ((cyc + f) % 4) != 1;
         in_data  = gen_byte(f, acc);
         if (in_ready && in_valid) acc++;
         if (out_valid && bit_en) begin
            if (obs < exp_q.size()) begin
               chk({out_tag, out_sym, out_bit} == exp_q[obs], req_q[obs], "stream item",
                   int'({out_tag, out_sym, out_bit}), int'(exp_q[obs]));
            end else begin
               chk(1'b0, "R7", "extra item", int'({out_tag, out_sym, out_bit}), 0);
            end
            obs++;
         end
         @(negedge clk);
      end
      bit_en   = 1'b0;
      in_valid = 1'b0;
      chk(obs == exp_q.size(), "R2", "item count", obs, exp_q.size());
      chk(acc == (den ? cnt : 0), "R9", "bytes accepted", acc, den ? cnt : 0);
      chk(ndone == (is_err ? 0 : 1), "R8", "done pulses", ndone, is_err ? 0 : 1);
      chk(!in_ready && !out_valid, "R8", "idle after frame", {in_ready, out_valid}, 0);
      @(negedge clk);
      chk(!done, "R8", "done one cycle", int'(done), 0);
      chk(err == is_err, "R5", "err held until next start", int'(err), int'(is_err));
   endtask

   initial begin
      int f;
      f = 0;
      repeat (3) @(negedge clk);
      chk(!out_valid && !in_ready && !done && !err, "R10", "reset outputs",
          {out_valid, in_ready, done, err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && !in_ready && !done && !err, "R10", "idle after reset release",
          {out_valid, in_ready, done, err}, 0);
      for (int cnt = 0; cnt < 4; cnt++)
         for (int den = 0; den < 2; den++)
            for (int pen = 0; pen < 2; pen++)
               for (int podd = 0; podd < 2; podd++)
                  for (int pinv = 0; pinv < 2; pinv++)
                     for (int sel = 0; sel < 4; sel++) begin
                        run_frame(cnt, den[0], pen[0], podd[0], pinv[0], sel, f);
                        f++;
                     end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule